// File: doc/BRIEF.md
# Serial Command Register File for a Multiplexed LED Display

This block receives 16-bit command words over a write-only, three-wire serial link (serial clock, active-low select, data in) and keeps the settings and per-digit data that a display scanner needs. The serial pins are oversampled in the system clock domain. Bits shift in on rising serial-clock edges while select is low. The shift register is copied and executed when select rises, so the command is always the last sixteen bits shifted in.

Each word carries an 8-bit register address in its upper byte and an 8-bit value in its lower byte. The register file holds a per-digit decode mask, an intensity level, a scan limit, a configuration word (run/shutdown, blink rate, blink enable) and a display-test flag. It also holds two planes of digit bytes. A digit write can target either plane alone or both planes at once. Two configuration bits are actions rather than state: one clears every digit byte, and one issues a timing-sync pulse for the scanner. Both appear as single-cycle pulses.

Top module: `sercmd_regfile`

## Requirements
- R1: After reset, decode is 0x00, intensity is 0, scan limit is 4, run, blink-fast and blink-enable are 0, display test is 0, every digit byte in both planes is 0, and neither pulse is high.
- R2: A word is shifted in most significant bit first on rising serial-clock edges while select is low. Bits 15..8 are the address and bits 7..0 are the data. The command takes effect after select rises.
- R3: Serial-clock edges while select is high do not change the shift register.
- R4: The executed word is the last 16 bits shifted in, over this and earlier transfers. More than 16 bits keep the newest 16. Fewer than 16 bits combine with bits left over from before.
- R5: Address 0x20+d writes digit d of plane 0 only, 0x40+d writes plane 1 only, and 0x60+d writes both planes with the same byte, for d in 0..7.
- R6: Address 0x01 loads the 8-bit decode mask. 0x02 loads intensity from data bits 3..0. 0x03 loads scan limit from data bits 2..0. 0x07 loads display test from data bit 0.
- R7: Address 0x04 loads run from data bit 0 (1 = normal operation), blink-fast from bit 2 and blink-enable from bit 3. Bit 1 has no effect.
- R8: In a 0x04 write, data bit 5 clears all digit bytes in both planes and raises the clear pulse for exactly one cycle. Data bit 4 raises the sync pulse for exactly one cycle. Neither bit is stored.
- R9: Address 0x00, 0x05, 0x06 and every address not listed above change no register and raise no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial clock, asynchronous |
| csn_i | input | 1 | Active-low select, asynchronous |
| sdin_i | input | 1 | Serial data, asynchronous |
| decode_o | output | 8 | Per-digit decode mask |
| intensity_o | output | 4 | Brightness level |
| scan_limit_o | output | 3 | Highest scanned digit index |
| run_o | output | 1 | 1 = normal operation, 0 = shutdown |
| blink_fast_o | output | 1 | Blink rate select |
| blink_en_o | output | 1 | Global blink enable |
| disp_test_o | output | 1 | Display-test flag |
| plane0_o | output | 64 | Plane 0 digit bytes, digit d at bits 8d+7..8d |
| plane1_o | output | 64 | Plane 1 digit bytes, digit d at bits 8d+7..8d |
| clear_pulse_o | output | 1 | One-cycle pulse when digit data is cleared |
| sync_pulse_o | output | 1 | One-cycle timing-sync pulse |

## Verification
The hardest state to reach is a word built from bits of two transfers. To reach it, the stimulus sends an over-long transfer and then a short one, so that stale shift-register content takes part in the executed command. Serial-clock activity while select is high is also sent between transfers. A sweep writes every one of the 256 addresses in turn with varying data. This covers the unmapped gaps, all three plane-select encodings and configuration words that carry clear and sync bits. A bench model of the shift register and register file predicts every output and pulse count.

// File: rtl/sercmd_pkg.sv
package sercmd_pkg;

   localparam int WORD_W = 16;
   localparam int ADDR_W = 8;
   localparam int DATA_W = 8;

   localparam logic [ADDR_W-1:0] ADR_NOP       = 8'h00;
   localparam logic [ADDR_W-1:0] ADR_DECODE    = 8'h01;
   localparam logic [ADDR_W-1:0] ADR_INTENSITY = 8'h02;
   localparam logic [ADDR_W-1:0] ADR_SCANLIM   = 8'h03;
   localparam logic [ADDR_W-1:0] ADR_CONFIG    = 8'h04;
   localparam logic [ADDR_W-1:0] ADR_TEST      = 8'h07;

   // plane-select field in address bits 7..5
   localparam logic [2:0] PSEL_P0   = 3'b001;
   localparam logic [2:0] PSEL_P1   = 3'b010;
   localparam logic [2:0] PSEL_BOTH = 3'b011;

   // configuration data bit positions
   localparam int CFG_RUN   = 0;
   localparam int CFG_FAST  = 2;
   localparam int CFG_BLINK = 3;
   localparam int CFG_SYNC  = 4;
   localparam int CFG_CLEAR = 5;

   typedef struct packed {
      logic run;
      logic blink_fast;
      logic blink_en;
   } cfg_t;

   localparam cfg_t CFG_RESET = '{run: 1'b0, blink_fast: 1'b0, blink_en: 1'b0};

endpackage

// File: rtl/sercmd_sync.sv
module sercmd_sync #(
   parameter int               STAGES  = 2,
   parameter int               WIDTH   = 3,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("sercmd_sync: STAGES must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("sercmd_sync: WIDTH must be positive");
   end

   logic [STAGES-1:0][WIDTH-1:0] stg_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stg_q <= {STAGES{RST_VAL}};
      end else begin
         stg_q <= {stg_q[STAGES-2:0], d_i};
      end
   end

   assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/sercmd_shifter.sv
module sercmd_shifter #(
   parameter int WORD_W = sercmd_pkg::WORD_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sclk_s,
   input  logic              csn_s,
   input  logic              sdin_s,
   output logic              cmd_valid_o,
   output logic [WORD_W-1:0] cmd_word_o
);

   if (WORD_W < 2) begin : g_bad_word
      $error("sercmd_shifter: WORD_W must be at least 2");
   end

   logic              sclk_q;
   logic              csn_q;
   logic              sclk_rise;
   logic              cs_rise;
   logic [WORD_W-1:0] shift_q;

   assign sclk_rise = sclk_s & ~sclk_q;
   assign cs_rise   = csn_s & ~csn_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_q <= 1'b0;
         csn_q  <= 1'b1;
      end else begin
         sclk_q <= sclk_s;
         csn_q  <= csn_s;
      end
   end

   // never cleared: short transfers reuse leftover bits (R4)
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shift_q <= '0;
      end else if (sclk_rise && !csn_s) begin
         shift_q <= {shift_q[WORD_W-2:0], sdin_s};
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_valid_o <= 1'b0;
         cmd_word_o  <= '0;
      end else begin
         cmd_valid_o <= cs_rise;
         if (cs_rise) begin
            cmd_word_o <= shift_q;
         end
      end
   end

   a_r3_hold_when_deselected : assert property (@(posedge clk) disable iff (!rst_n)
      $past(csn_s) |-> $stable(shift_q));

   a_r2_single_cmd_strobe : assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid_o |=> !cmd_valid_o);

   a_r2_word_held_between_cmds : assert property (@(posedge clk) disable iff (!rst_n)
      !cmd_valid_o |-> $stable(cmd_word_o));

endmodule

// File: rtl/sercmd_regbank.sv
module sercmd_regbank
   import sercmd_pkg::*;
#(
   parameter int NUM_DIGITS = 8,
   parameter int INTENS_W   = 4,
   parameter int SCAN_W     = 3,
   localparam int PLANE_W   = NUM_DIGITS * DATA_W
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cmd_valid_i,
   input  logic [WORD_W-1:0]   cmd_word_i,
   output logic [DATA_W-1:0]   decode_o,
   output logic [INTENS_W-1:0] intensity_o,
   output logic [SCAN_W-1:0]   scan_limit_o,
   output cfg_t                cfg_o,
   output logic                disp_test_o,
   output logic [PLANE_W-1:0]  plane0_o,
   output logic [PLANE_W-1:0]  plane1_o,
   output logic                clear_pulse_o,
   output logic                sync_pulse_o
);

   if (NUM_DIGITS < 1 || NUM_DIGITS > 8) begin : g_bad_digits
      $error("sercmd_regbank: NUM_DIGITS must be 1..8");
   end
   if (INTENS_W < 1 || INTENS_W > DATA_W) begin : g_bad_intens
      $error("sercmd_regbank: INTENS_W out of range");
   end
   if (SCAN_W < 1 || SCAN_W > DATA_W) begin : g_bad_scan
      $error("sercmd_regbank: SCAN_W out of range");
   end

   localparam logic [SCAN_W-1:0] SCAN_RST = SCAN_W'(4);

   logic [ADDR_W-1:0] addr;
   logic [DATA_W-1:0] data;
   logic              is_digit;
   logic              wr_p0;
   logic              wr_p1;
   logic              wr_decode;
   logic              wr_intens;
   logic              wr_scan;
   logic              wr_cfg;
   logic              wr_test;
   logic              mapped;
   logic              do_clear;

   assign addr = cmd_word_i[WORD_W-1 -: ADDR_W];
   assign data = cmd_word_i[DATA_W-1:0];

   always_comb begin
      is_digit = (addr[4:3] == 2'b00) && (int'(addr[2:0]) < NUM_DIGITS) &&
                 ((addr[7:5] == PSEL_P0) || (addr[7:5] == PSEL_P1) ||
                  (addr[7:5] == PSEL_BOTH));
      wr_p0     = cmd_valid_i && is_digit && addr[5];
      wr_p1     = cmd_valid_i && is_digit && addr[6];
      wr_decode = cmd_valid_i && (addr == ADR_DECODE);
      wr_intens = cmd_valid_i && (addr == ADR_INTENSITY);
      wr_scan   = cmd_valid_i && (addr == ADR_SCANLIM);
      wr_cfg    = cmd_valid_i && (addr == ADR_CONFIG);
      wr_test   = cmd_valid_i && (addr == ADR_TEST);
      mapped    = is_digit || (addr == ADR_DECODE) || (addr == ADR_INTENSITY) ||
                  (addr == ADR_SCANLIM) || (addr == ADR_CONFIG) || (addr == ADR_TEST);
      do_clear  = wr_cfg && data[CFG_CLEAR];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         decode_o     <= '0;
         intensity_o  <= '0;
         scan_limit_o <= SCAN_RST;
         cfg_o        <= CFG_RESET;
         disp_test_o  <= 1'b0;
      end else begin
         if (wr_decode) decode_o     <= data;
         if (wr_intens) intensity_o  <= data[INTENS_W-1:0];
         if (wr_scan)   scan_limit_o <= data[SCAN_W-1:0];
         if (wr_test)   disp_test_o  <= data[0];
         if (wr_cfg) begin
            cfg_o.run        <= data[CFG_RUN];
            cfg_o.blink_fast <= data[CFG_FAST];
            cfg_o.blink_en   <= data[CFG_BLINK];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         clear_pulse_o <= 1'b0;
         sync_pulse_o  <= 1'b0;
      end else begin
         clear_pulse_o <= do_clear;
         sync_pulse_o  <= wr_cfg && data[CFG_SYNC];
      end
   end

   for (genvar g = 0; g < NUM_DIGITS; g++) begin : g_digit
      localparam logic [2:0] IDX = 3'(g);
      logic [DATA_W-1:0] p0_q;
      logic [DATA_W-1:0] p1_q;
      logic              hit;

      assign hit = (addr[2:0] == IDX);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            p0_q <= '0;
            p1_q <= '0;
         end else if (do_clear) begin
            p0_q <= '0;
            p1_q <= '0;
         end else begin
            if (wr_p0 && hit) p0_q <= data;
            if (wr_p1 && hit) p1_q <= data;
         end
      end

      assign plane0_o[g*DATA_W +: DATA_W] = p0_q;
      assign plane1_o[g*DATA_W +: DATA_W] = p1_q;
   end

   a_r8_clear_empties_planes : assert property (@(posedge clk) disable iff (!rst_n)
      clear_pulse_o |-> (plane0_o == '0 && plane1_o == '0));

   a_r8_clear_one_cycle : assert property (@(posedge clk) disable iff (!rst_n)
      clear_pulse_o |=> !clear_pulse_o);

   a_r8_sync_one_cycle : assert property (@(posedge clk) disable iff (!rst_n)
      sync_pulse_o |=> !sync_pulse_o);

   a_r9_unmapped_no_change : assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid_i && !mapped) |=> ($stable(plane0_o) && $stable(plane1_o) &&
         $stable(decode_o) && $stable(intensity_o) && $stable(scan_limit_o) &&
         $stable(cfg_o) && $stable(disp_test_o) && !clear_pulse_o && !sync_pulse_o));

   a_r5_plane0_only_keeps_p1 : assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid_i && addr[7:5] == PSEL_P0) |=> $stable(plane1_o));

   a_r5_plane1_only_keeps_p0 : assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid_i && addr[7:5] == PSEL_P1) |=> $stable(plane0_o));

endmodule

// File: rtl/sercmd_regfile.sv
module sercmd_regfile #(
   parameter int SYNC_STAGES = 2,
   parameter int NUM_DIGITS  = 8,
   parameter int INTENS_W    = 4,
   parameter int SCAN_W      = 3,
   localparam int PLANE_W    = NUM_DIGITS * sercmd_pkg::DATA_W
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                sclk_i,
   input  logic                csn_i,
   input  logic                sdin_i,
   output logic [7:0]          decode_o,
   output logic [INTENS_W-1:0] intensity_o,
   output logic [SCAN_W-1:0]   scan_limit_o,
   output logic                run_o,
   output logic                blink_fast_o,
   output logic                blink_en_o,
   output logic                disp_test_o,
   output logic [PLANE_W-1:0]  plane0_o,
   output logic [PLANE_W-1:0]  plane1_o,
   output logic                clear_pulse_o,
   output logic                sync_pulse_o
);

   import sercmd_pkg::*;

   logic [2:0]        pins_s;
   logic              cmd_valid;
   logic [WORD_W-1:0] cmd_word;
   cfg_t              cfg;

   // bit order: {sclk, csn, sdin}; select idles high
   sercmd_sync #(
      .STAGES  (SYNC_STAGES),
      .WIDTH   (3),
      .RST_VAL (3'b010)
   ) sync_i (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   ({sclk_i, csn_i, sdin_i}),
      .q_o   (pins_s)
   );

   sercmd_shifter #(
      .WORD_W (WORD_W)
   ) shift_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .sclk_s      (pins_s[2]),
      .csn_s       (pins_s[1]),
      .sdin_s      (pins_s[0]),
      .cmd_valid_o (cmd_valid),
      .cmd_word_o  (cmd_word)
   );

   sercmd_regbank #(
      .NUM_DIGITS (NUM_DIGITS),
      .INTENS_W   (INTENS_W),
      .SCAN_W     (SCAN_W)
   ) bank_i (
      .clk           (clk),
      .rst_n         (rst_n),
      .cmd_valid_i   (cmd_valid),
      .cmd_word_i    (cmd_word),
      .decode_o      (decode_o),
      .intensity_o   (intensity_o),
      .scan_limit_o  (scan_limit_o),
      .cfg_o         (cfg),
      .disp_test_o   (disp_test_o),
      .plane0_o      (plane0_o),
      .plane1_o      (plane1_o),
      .clear_pulse_o (clear_pulse_o),
      .sync_pulse_o  (sync_pulse_o)
   );

   assign run_o        = cfg.run;
   assign blink_fast_o = cfg.blink_fast;
   assign blink_en_o   = cfg.blink_en;

   a_r1_pulses_low_after_reset : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (!clear_pulse_o && !sync_pulse_o));

endmodule

// File: tb/sercmd_regfile_tb_top.sv
module sercmd_regfile_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sclk_i = 1'b0;
   logic        csn_i = 1'b1;
   logic        sdin_i = 1'b0;
   logic [7:0]  decode_o;
   logic [3:0]  intensity_o;
   logic [2:0]  scan_limit_o;
   logic        run_o, blink_fast_o, blink_en_o, disp_test_o;
   logic [63:0] plane0_o, plane1_o;
   logic        clear_pulse_o, sync_pulse_o;

   always #5 clk = ~clk;

   sercmd_regfile dut_i (
      .clk(clk), .rst_n(rst_n), .sclk_i(sclk_i), .csn_i(csn_i), .sdin_i(sdin_i),
      .decode_o(decode_o), .intensity_o(intensity_o), .scan_limit_o(scan_limit_o),
      .run_o(run_o), .blink_fast_o(blink_fast_o), .blink_en_o(blink_en_o),
      .disp_test_o(disp_test_o), .plane0_o(plane0_o), .plane1_o(plane1_o),
      .clear_pulse_o(clear_pulse_o), .sync_pulse_o(sync_pulse_o)
   );

   int checks = 0;
   int errors = 0;
   int clear_seen = 0;
   int sync_seen = 0;

   // model state
   logic [15:0] m_shift = 16'h0000;
   logic [7:0]  m_dec = 8'h00;
   logic [3:0]  m_int = 4'h0;
   logic [2:0]  m_scan = 3'd4;
   logic        m_run = 1'b0, m_fast = 1'b0, m_blink = 1'b0, m_test = 1'b0;
   logic [63:0] m_p0 = '0, m_p1 = '0;
   int          m_clear = 0, m_sync = 0;

   always @(posedge clk) begin
      if (clear_pulse_o) clear_seen <= clear_seen + 1;
      if (sync_pulse_o)  sync_seen  <= sync_seen + 1;
   end

   task automatic chk(input string tag, input string what, input logic [63:0] act,
                      input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   task automatic check_all(input string tag);
      chk(tag, "decode", 64'(decode_o), 64'(m_dec));
      chk(tag, "intensity", 64'(intensity_o), 64'(m_int));
      chk(tag, "scan_limit", 64'(scan_limit_o), 64'(m_scan));
      chk(tag, "cfg", 64'({run_o, blink_fast_o, blink_en_o}), 64'({m_run, m_fast, m_blink}));
      chk(tag, "disp_test", 64'(disp_test_o), 64'(m_test));
      chk(tag, "plane0", plane0_o, m_p0);
      chk(tag, "plane1", plane1_o, m_p1);
      chk(tag, "clear pulses", 64'(clear_seen), 64'(m_clear));
      chk(tag, "sync pulses", 64'(sync_seen), 64'(m_sync));
   endtask

   // model of the command decode from the requirements
   task automatic model_exec(input logic [15:0] w);
      logic [7:0] a;
      logic [7:0] d;
      int idx;
      a = w[15:8];
      d = w[7:0];
      idx = int'(a[2:0]);
      case (a)
         8'h01: m_dec = d;
         8'h02: m_int = d[3:0];
         8'h03: m_scan = d[2:0];
         8'h07: m_test = d[0];
         8'h04: begin
            m_run = d[0]; m_fast = d[2]; m_blink = d[3];
            if (d[5]) begin m_p0 = '0; m_p1 = '0; m_clear++; end
            if (d[4]) m_sync++;
         end
         default: begin
            if (a[4:3] == 2'b00 && (a[7:5] == 3'b001 || a[7:5] == 3'b011))
               m_p0[idx*8 +: 8] = d;
            if (a[4:3] == 2'b00 && (a[7:5] == 3'b010 || a[7:5] == 3'b011))
               m_p1[idx*8 +: 8] = d;
         end
      endcase
   endtask

   task automatic wait_clk(input int n);
      repeat (n) @(posedge clk);
      #2;
   endtask

   task automatic send_bit(input logic b, input logic selected);
      sdin_i = b;
      wait_clk(3);
      sclk_i = 1'b1;
      wait_clk(3);
      sclk_i = 1'b0;
      wait_clk(3);
      if (selected) m_shift = {m_shift[14:0], b};
   endtask

   // sends the low n bits of val, most significant first
   task automatic xfer(input logic [63:0] val, input int n);
      csn_i = 1'b0;
      wait_clk(3);
      for (int i = n - 1; i >= 0; i--) send_bit(val[i], 1'b1);
      csn_i = 1'b1;
      model_exec(m_shift);
      wait_clk(8);
   endtask

   task automatic write16(input logic [7:0] a, input logic [7:0] d);
      xfer(64'({a, d}), 16);
   endtask

   initial begin
      repeat (20000 * 10) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      wait_clk(4);
      rst_n = 1'b1;
      wait_clk(4);
      check_all("R1");

      // R6 control registers
      write16(8'h01, 8'hA7); check_all("R6");
      write16(8'h02, 8'hF9); check_all("R6");
      write16(8'h03, 8'h7E); check_all("R6");
      write16(8'h07, 8'h01); check_all("R6");

      // R7 configuration, bit 1 set but ignored
      write16(8'h04, 8'h0F); check_all("R7");
      write16(8'h04, 8'h02); check_all("R7");

      // R5 plane selection per digit
      for (int d = 0; d < 8; d++) begin
         write16(8'h20 + 8'(d), 8'h10 + 8'(d)); check_all("R5");
         write16(8'h40 + 8'(d), 8'h80 + 8'(d)); check_all("R5");
      end
      write16(8'h63, 8'h5A); check_all("R5");

      // R8 sync alone, then clear plus sync
      write16(8'h04, 8'h11); check_all("R8");
      write16(8'h04, 8'h39); check_all("R8");

      // R3 clock activity while deselected
      for (int i = 0; i < 16; i++) send_bit(1'b1, 1'b0);
      check_all("R3");
      write16(8'h22, 8'h3C); check_all("R3");

      // R4 over-long then short transfer
      xfer(64'hFFF0_2155, 20); check_all("R4");
      xfer(64'h0000_0000_0000_0046, 8); check_all("R4");
      xfer(64'h0000_0000_0000_0004, 4); check_all("R4");

      // R9 specific unmapped addresses
      write16(8'h00, 8'hFF); check_all("R9");
      write16(8'h06, 8'h3F); check_all("R9");
      write16(8'h05, 8'h3F); check_all("R9");
      write16(8'h28, 8'hEE); check_all("R9");

      // R2 sweep of all addresses with varying data
      for (int a = 0; a < 256; a++) begin
         write16(8'(a), 8'((a * 37 + 11) & 255));
         check_all("R2");
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule